// File: doc/BRIEF.md
# Decimal Coefficient Rounding Unit

This block takes an unrounded decimal result, made of a sign, a BCD coefficient of up to 32 digits and a signed binary exponent, and brings it down to a 16-digit coefficient. It removes one decimal digit per clock from the low end and adds one to the exponent for every digit removed. The last digit removed is kept as a guard digit. Any nonzero digit removed before it sets a sticky bit. When at most 16 significant digits remain, one further cycle applies the requested rounding mode by adding one in the least significant digit where needed. That cycle also reports whether the delivered value differs from the exact one.

An operation is launched with a one-cycle `start` while the unit is idle. `busy` stays high while the operation runs. A one-cycle `done` marks the cycle in which the result outputs become valid, and they hold that value until the next `done`. An inexact result either sets a flag that is cleared only by reset, or raises a data exception, depending on the mask input sampled at `start`. An exponent that ends up above the format maximum raises an overflow indication but is not otherwise handled.

Top module: `dec_round_unit`

## Requirements
- R1: After reset `busy`, `done`, `inexact`, `overflow`, `data_exc` and `inexact_flag` are 0, and `coef_out` and `exp_out` are 0.
- R2: A `start` seen while idle loads `sign_in`, `coef_in`, `exp_in`, `rmode` and `inexact_mask`, and `busy` is high on the next cycle. `done` is a one-cycle pulse that rises k+2 clock edges after the start edge, where k is the number of digit shifts. `busy` and `done` are never high together. A `start` seen while busy is ignored.
- R3: While digits 16..31 of the coefficient (4-bit BCD nibbles, digit 0 in bits 3:0) are not all zero, the coefficient shifts right one digit and the exponent grows by 1. A coefficient that already fits in 16 digits is not shifted, and the exponent is unchanged.
- R4: `inexact` is 1 exactly when the guard digit is nonzero or the sticky bit is set. A result whose removed digits are all zero is exact.
- R5: `rmode` 1 (toward zero) never increments. Codes 5, 6 and 7 behave the same as code 1.
- R6: `rmode` 2 (toward plus) increments an inexact positive result. `rmode` 3 (toward minus) increments an inexact negative result. Neither mode increments an exact result or a result of the other sign.
- R7: `rmode` 0 (nearest, ties to even) increments when guard > 5, or when guard = 5 and sticky is set, or when guard = 5, sticky is clear and the least significant digit is odd.
- R8: `rmode` 4 (nearest, ties away) increments when guard >= 5, whatever the sticky bit.
- R9: If the increment carries out of the 16th digit, the coefficient becomes 1000000000000000 and the exponent grows by one more.
- R10: `overflow` is 1 with the result when the final exponent is greater than 369.
- R11: For an inexact result with mask 0, `inexact_flag` is set and remains set until reset. With mask 1, `data_exc` is set with the result and the flag is left as it was. `data_exc` is 0 for exact results.
- R12: `coef_out`, `exp_out`, `sign_out`, `inexact`, `overflow` and `data_exc` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation (accepted only when idle) |
| sign_in | input | 1 | Sign of the intermediate result, 1 = negative |
| coef_in | input | 128 | Intermediate coefficient, 32 BCD digits |
| exp_in | input | 16 | Intermediate exponent, two's complement |
| rmode | input | 3 | Rounding mode code |
| inexact_mask | input | 1 | 1 routes an inexact result to `data_exc` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result outputs updated |
| sign_out | output | 1 | Sign of the result |
| coef_out | output | 64 | Rounded coefficient, 16 BCD digits |
| exp_out | output | 16 | Final exponent, two's complement |
| inexact | output | 1 | Result differs from the exact value |
| overflow | output | 1 | Final exponent above 369 |
| data_exc | output | 1 | Inexact result with the mask set |
| inexact_flag | output | 1 | Sticky inexact flag, cleared by reset only |

## Verification
The rounding cycle can both produce a carry out of the top digit and add a further exponent step. That step can push the exponent over the limit, so a carry, a renormalisation and an overflow decision can all fall in the same cycle. This is provoked in two ways: seventeen nines under toward-plus, and a just-fitting coefficient shifted once from an exponent at the limit. Each case is judged on the coefficient, the exponent and the overflow bit of the same `done` pulse. A second start pulse during a running operation is also issued, and the result must belong to the first operand.

// File: rtl/dec_round_pkg.sv
package dec_round_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_UP        = 3'd2,
    RM_DOWN      = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ROUND = 2'd2
  } state_e;
endpackage

// File: rtl/dec_width_detect.sv
module dec_width_detect #(
  parameter int unsigned IN_DIGITS  = 32,
  parameter int unsigned OUT_DIGITS = 16
) (
  input  logic [IN_DIGITS*4-1:0] coef,
  output logic                   too_wide
);
  localparam int unsigned EXTRA = IN_DIGITS - OUT_DIGITS;

  logic [EXTRA-1:0] digit_nz;

  for (genvar i = 0; i < EXTRA; i++) begin : g_nz
    assign digit_nz[i] = |coef[(OUT_DIGITS+i)*4 +: 4];
  end

  assign too_wide = |digit_nz;
endmodule

// File: rtl/dec_round_decide.sv
module dec_round_decide
  import dec_round_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sign,
  input  logic [3:0] guard,
  input  logic       sticky,
  input  logic       lsd_odd,
  output logic       incr,
  output logic       inexact
);
  logic g_above, g_half, g_atleast;

  always_comb begin
    g_above   = guard > 4'd5;
    g_half    = guard == 4'd5;
    g_atleast = guard >= 4'd5;
    inexact   = (guard != 4'd0) | sticky;
    case (rmode_e'(mode))
      RM_NEAR_EVEN: incr = g_above | (g_half & (sticky | lsd_odd));
      RM_NEAR_AWAY: incr = g_atleast;
      RM_UP:        incr = inexact & ~sign;
      RM_DOWN:      incr = inexact & sign;
      default:      incr = 1'b0;
    endcase
  end
endmodule

// File: rtl/dec_bcd_inc.sv
module dec_bcd_inc #(
  parameter int unsigned DIGITS = 16
) (
  input  logic [DIGITS*4-1:0] a,
  input  logic                cin,
  output logic [DIGITS*4-1:0] sum,
  output logic                cout
);
  logic [DIGITS:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    logic       wrap;
    assign d              = a[i*4 +: 4];
    assign wrap           = carry[i] & (d == 4'd9);
    assign sum[i*4 +: 4]  = wrap ? 4'd0 : (d + {3'b000, carry[i]});
    assign carry[i+1]     = wrap;
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/dec_round_unit.sv
module dec_round_unit
  import dec_round_pkg::*;
#(
  parameter int unsigned IN_DIGITS  = 32,
  parameter int unsigned OUT_DIGITS = 16,
  parameter int unsigned EXP_W      = 16,
  parameter int          EXP_MAX    = 369
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     sign_in,
  input  logic [IN_DIGITS*4-1:0]   coef_in,
  input  logic signed [EXP_W-1:0]  exp_in,
  input  logic [2:0]               rmode,
  input  logic                     inexact_mask,
  output logic                     busy,
  output logic                     done,
  output logic                     sign_out,
  output logic [OUT_DIGITS*4-1:0]  coef_out,
  output logic signed [EXP_W-1:0]  exp_out,
  output logic                     inexact,
  output logic                     overflow,
  output logic                     data_exc,
  output logic                     inexact_flag
);
  localparam int unsigned IN_W  = IN_DIGITS * DIGIT_W;
  localparam int unsigned OUT_W = OUT_DIGITS * DIGIT_W;
  localparam logic signed [EXP_W-1:0] EXP_LIMIT = EXP_W'(EXP_MAX);
  localparam logic [OUT_W-1:0] COEF_CARRY = OUT_W'(1) << ((OUT_DIGITS - 1) * DIGIT_W);

  // reset synchronizer: asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // working state
  state_e                  state_q, state_d;
  logic [IN_W-1:0]         work_q, work_d;
  logic signed [EXP_W-1:0] wexp_q, wexp_d;
  logic [3:0]              guard_q, guard_d;
  logic                    sticky_q, sticky_d;
  logic                    wsign_q;
  logic [2:0]              mode_q;
  logic                    mask_q;

  // result state
  logic                    done_q, done_d;
  logic                    rsign_q;
  logic [OUT_W-1:0]        rcoef_q, rcoef_d;
  logic signed [EXP_W-1:0] rexp_q, rexp_d;
  logic                    rinex_q, rovf_q, rexc_q, rovf_d, rexc_d;
  logic                    flag_q, flag_d;

  // enables
  logic load_en, shift_en, round_en;

  // datapath helpers
  logic             too_wide;
  logic             incr, inex_now;
  logic [OUT_W-1:0] inc_sum;
  logic             inc_cout;

  dec_width_detect #(
    .IN_DIGITS  (IN_DIGITS),
    .OUT_DIGITS (OUT_DIGITS)
  ) u_width (
    .coef     (work_q),
    .too_wide (too_wide)
  );

  dec_round_decide u_decide (
    .mode    (mode_q),
    .sign    (wsign_q),
    .guard   (guard_q),
    .sticky  (sticky_q),
    .lsd_odd (work_q[0]),
    .incr    (incr),
    .inexact (inex_now)
  );

  dec_bcd_inc #(
    .DIGITS (OUT_DIGITS)
  ) u_inc (
    .a    (work_q[OUT_W-1:0]),
    .cin  (incr),
    .sum  (inc_sum),
    .cout (inc_cout)
  );

  assign load_en  = (state_q == ST_IDLE)  & start;
  assign shift_en = (state_q == ST_SHIFT) & too_wide;
  assign round_en = (state_q == ST_ROUND);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    work_d   = work_q;
    wexp_d   = wexp_q;
    guard_d  = guard_q;
    sticky_d = sticky_q;
    rcoef_d  = rcoef_q;
    rexp_d   = rexp_q;
    rovf_d   = rovf_q;
    rexc_d   = rexc_q;
    flag_d   = flag_q;
    done_d   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SHIFT;
          work_d   = coef_in;
          wexp_d   = exp_in;
          guard_d  = 4'd0;
          sticky_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (too_wide) begin
          work_d   = work_q >> DIGIT_W;
          wexp_d   = wexp_q + 1'b1;
          guard_d  = work_q[3:0];
          sticky_d = sticky_q | (guard_q != 4'd0);
        end else begin
          state_d = ST_ROUND;
        end
      end
      ST_ROUND: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (inc_cout) begin
          rcoef_d = COEF_CARRY;
          rexp_d  = wexp_q + 1'b1;
        end else begin
          rcoef_d = inc_sum;
          rexp_d  = wexp_q;
        end
        rovf_d = rexp_d > EXP_LIMIT;
        rexc_d = inex_now & mask_q;
        flag_d = flag_q | (inex_now & ~mask_q);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      work_q   <= '0;
      wexp_q   <= '0;
      guard_q  <= '0;
      sticky_q <= 1'b0;
      wsign_q  <= 1'b0;
      mode_q   <= '0;
      mask_q   <= 1'b0;
      done_q   <= 1'b0;
      rsign_q  <= 1'b0;
      rcoef_q  <= '0;
      rexp_q   <= '0;
      rinex_q  <= 1'b0;
      rovf_q   <= 1'b0;
      rexc_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load_en | shift_en) begin
        work_q   <= work_d;
        wexp_q   <= wexp_d;
        guard_q  <= guard_d;
        sticky_q <= sticky_d;
      end
      if (load_en) begin
        wsign_q <= sign_in;
        mode_q  <= rmode;
        mask_q  <= inexact_mask;
      end
      if (round_en) begin
        rsign_q <= wsign_q;
        rcoef_q <= rcoef_d;
        rexp_q  <= rexp_d;
        rinex_q <= inex_now;
        rovf_q  <= rovf_d;
        rexc_q  <= rexc_d;
        flag_q  <= flag_d;
      end
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign sign_out     = rsign_q;
  assign coef_out     = rcoef_q;
  assign exp_out      = rexp_q;
  assign inexact      = rinex_q;
  assign overflow     = rovf_q;
  assign data_exc     = rexc_q;
  assign inexact_flag = flag_q;
endmodule

// File: rtl/dec_round_unit_chk.sv
module dec_round_unit_chk #(
  parameter int unsigned OUT_DIGITS = 16,
  parameter int unsigned EXP_W      = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [OUT_DIGITS*4-1:0] coef_out,
  input logic [EXP_W-1:0]        exp_out,
  input logic                    inexact,
  input logic                    overflow,
  input logic                    data_exc,
  input logic                    inexact_flag
);
  function automatic logic all_bcd(input logic [OUT_DIGITS*4-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < OUT_DIGITS; i++) begin
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy); // R2
  AST_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> all_bcd(coef_out)); // R3
  AST_OVF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> done); // R10
  AST_EXC_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    data_exc |-> inexact); // R11
  AST_FLAG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_flag |=> inexact_flag); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(coef_out) && $stable(exp_out) && $stable(inexact))); // R12
endmodule

bind dec_round_unit dec_round_unit_chk #(
  .OUT_DIGITS (OUT_DIGITS),
  .EXP_W      (EXP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .coef_out     (coef_out),
  .exp_out      (exp_out),
  .inexact      (inexact),
  .overflow     (overflow),
  .data_exc     (data_exc),
  .inexact_flag (inexact_flag)
);

// File: tb/dec_round_unit_bench.sv
module dec_round_unit_bench;
  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                sign_in = 1'b0;
  logic [127:0]        coef_in = '0;
  logic signed [15:0]  exp_in = '0;
  logic [2:0]          rmode = '0;
  logic                inexact_mask = 1'b0;
  logic                busy, done, sign_out, inexact, overflow, data_exc, inexact_flag;
  logic [63:0]         coef_out;
  logic signed [15:0]  exp_out;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk; // 125 MHz

  dec_round_unit u_dec_round_unit (
    .clk (clk), .rst_n (rst_n), .start (start), .sign_in (sign_in),
    .coef_in (coef_in), .exp_in (exp_in), .rmode (rmode),
    .inexact_mask (inexact_mask), .busy (busy), .done (done),
    .sign_out (sign_out), .coef_out (coef_out), .exp_out (exp_out),
    .inexact (inexact), .overflow (overflow), .data_exc (data_exc),
    .inexact_flag (inexact_flag)
  );

  typedef struct packed {
    logic        sgn;
    logic [2:0]  md;
    logic        mk;
    logic [15:0] ein;
    logic [127:0] cin;
    logic [63:0] xc;
    logic [15:0] xe;
    logic        xi;
    logic        xo;
    logic [7:0]  xcy;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R6 R3: worked example, toward plus, positive
    '{1'b0, 3'd2, 1'b1, -16'sd15, 128'h254469004940773233, 64'h2544690049407733, -16'sd13, 1'b1, 1'b0, 8'd4},
    // R5: toward zero
    '{1'b0, 3'd1, 1'b1, -16'sd15, 128'h254469004940773233, 64'h2544690049407732, -16'sd13, 1'b1, 1'b0, 8'd4},
    // R6: toward minus, negative
    '{1'b1, 3'd3, 1'b1, -16'sd15, 128'h254469004940773233, 64'h2544690049407733, -16'sd13, 1'b1, 1'b0, 8'd4},
    // R6: toward plus, negative
    '{1'b1, 3'd2, 1'b1, -16'sd15, 128'h254469004940773233, 64'h2544690049407732, -16'sd13, 1'b1, 1'b0, 8'd4},
    // R5: reserved code 5
    '{1'b0, 3'd5, 1'b1, -16'sd15, 128'h254469004940773233, 64'h2544690049407732, -16'sd13, 1'b1, 1'b0, 8'd4},
    // R7: exact tie, even digit kept
    '{1'b0, 3'd0, 1'b1, 16'sd0, 128'h12345678901234565, 64'h1234567890123456, 16'sd1, 1'b1, 1'b0, 8'd3},
    // R8: exact tie, away
    '{1'b0, 3'd4, 1'b1, 16'sd0, 128'h12345678901234565, 64'h1234567890123457, 16'sd1, 1'b1, 1'b0, 8'd3},
    // R7: exact tie, odd digit bumped
    '{1'b0, 3'd0, 1'b1, 16'sd0, 128'h12345678901234575, 64'h1234567890123458, 16'sd1, 1'b1, 1'b0, 8'd3},
    // R7 R4: guard 5 with sticky
    '{1'b1, 3'd0, 1'b1, 16'sd0, 128'h123456789012345651, 64'h1234567890123457, 16'sd2, 1'b1, 1'b0, 8'd4},
    // R3: fits already, no shift, exact
    '{1'b0, 3'd2, 1'b1, -16'sd2, 128'h9999, 64'h9999, -16'sd2, 1'b0, 1'b0, 8'd2},
    // R4: zero digit removed, exact
    '{1'b0, 3'd2, 1'b1, 16'sd3, 128'h12345678901234560, 64'h1234567890123456, 16'sd4, 1'b0, 1'b0, 8'd3},
    // R9: carry out of top digit
    '{1'b0, 3'd2, 1'b1, 16'sd0, 128'h99999999999999999, 64'h1000000000000000, 16'sd2, 1'b1, 1'b0, 8'd3},
    // R10: exponent over the limit
    '{1'b0, 3'd1, 1'b1, 16'sd369, 128'h12345678901234560, 64'h1234567890123456, 16'sd370, 1'b0, 1'b1, 8'd3},
    // R10: exponent at the limit
    '{1'b0, 3'd1, 1'b1, 16'sd368, 128'h12345678901234560, 64'h1234567890123456, 16'sd369, 1'b0, 1'b0, 8'd3},
    // R3 R7: full 32 digits
    '{1'b0, 3'd0, 1'b1, -16'sd20, 128'h12345678901234567890123456789012, 64'h1234567890123457, -16'sd4, 1'b1, 1'b0, 8'd18},
    // R8: guard below half
    '{1'b1, 3'd4, 1'b1, -16'sd5, 128'h12345678901234564, 64'h1234567890123456, -16'sd4, 1'b1, 1'b0, 8'd3}
  };

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic run(input vec_t v, output int cyc);
    @(negedge clk);
    sign_in = v.sgn; coef_in = v.cin; exp_in = v.ein;
    rmode = v.md; inexact_mask = v.mk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    chk({busy, done, inexact, overflow, data_exc, inexact_flag} === 6'b0, "R1 flags in reset",
        64'({busy, done, inexact, overflow, data_exc, inexact_flag}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(coef_out === 64'd0 && exp_out === 16'sd0, "R1 result regs after reset", coef_out, 64'd0);
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", 64'({busy, done}), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run(v, cyc);
      chk(cyc == int'(v.xcy), "R2 done latency", 64'(cyc), 64'(v.xcy));
      chk(coef_out === v.xc, "R3 coefficient", coef_out, v.xc);
      chk(exp_out === v.xe, "R3 exponent", 64'(exp_out), 64'(v.xe));
      chk(sign_out === v.sgn, "R3 sign", 64'(sign_out), 64'(v.sgn));
      chk(inexact === v.xi, "R4 inexact", 64'(inexact), 64'(v.xi));
      chk(overflow === v.xo, "R10 overflow", 64'(overflow), 64'(v.xo));
      chk(data_exc === v.xi, "R11 data_exc with mask", 64'(data_exc), 64'(v.xi));
      chk(inexact_flag === 1'b0, "R11 flag untouched under mask", 64'(inexact_flag), 64'd0);
      @(negedge clk);
      chk(done === 1'b0, "R2 done one cycle", 64'(done), 64'd0);
    end

    // R12: results hold while idle
    repeat (5) @(negedge clk);
    chk(coef_out === VECS[NV-1].xc && exp_out === VECS[NV-1].xe, "R12 result held", coef_out, VECS[NV-1].xc);

    // R2: start while busy is ignored
    v = VECS[0];
    @(negedge clk);
    sign_in = v.sgn; coef_in = v.cin; exp_in = v.ein; rmode = v.md; inexact_mask = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    coef_in = 128'h9999; exp_in = 16'sd7; rmode = 3'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
    chk(coef_out === v.xc, "R2 second start ignored", coef_out, v.xc);
    @(negedge clk);
    chk(busy === 1'b0, "R2 idle after ignored start", 64'(busy), 64'd0);

    // R11: flag behaviour with mask clear
    v = VECS[10]; v.mk = 1'b0; // exact
    run(v, cyc);
    chk(inexact_flag === 1'b0, "R11 exact leaves flag", 64'(inexact_flag), 64'd0);
    chk(data_exc === 1'b0, "R11 no exc for exact", 64'(data_exc), 64'd0);
    v = VECS[1]; v.mk = 1'b0; // inexact
    run(v, cyc);
    chk(inexact_flag === 1'b1, "R11 flag set", 64'(inexact_flag), 64'd1);
    chk(data_exc === 1'b0, "R11 no exc with mask clear", 64'(data_exc), 64'd0);
    v = VECS[9]; v.mk = 1'b0; // exact
    run(v, cyc);
    chk(inexact_flag === 1'b1, "R11 flag sticks", 64'(inexact_flag), 64'd1);
    chk(coef_out === 64'h9999, "R3 short operand", coef_out, 64'h9999);

    // R1: reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(inexact_flag === 1'b0 && coef_out === 64'd0, "R1 reset clears", 64'(inexact_flag), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule